// File: doc/BRIEF.md
# Two-Input Second-Order Polynomial Controller

This block is a fixed-point, discrete-time controller for a second-order plant. It implements the polynomial control law R·u = T·uc − S·y, with R monic. Once per sample period it takes a commanded trajectory `uc` and a measured plant output `y`, and it produces one new control value `u`. Structurally it is a second-order recursive filter on the measured output. It adds a separate feed-forward path on the command, and it is computed by a single sequential multiply-accumulate unit.

The sample strobe comes from dividing the base clock by an integer. Eight coefficients live in a write-only shadow bank. A host or an on-line identifier/design stage can write that bank at any time. The whole bank is copied into the active set on the sample strobe, so a single update never mixes old and new coefficients. Each result is rounded, saturated to the output width, registered, and flagged by a one-cycle valid pulse. The histories of `uc`, `y` and `u` advance on that same edge.

Top module: `rst_ctrl`

## Requirements
- R1: `sample_tick` is high for exactly one cycle in every DIV cycles. The first pulse is in the DIV-th cycle after reset is released, and DIV must be at least 10. `uc_in` and `y_in` are captured on the rising edge that ends a `sample_tick` cycle.
- R2: `u_valid` is high for exactly one cycle. It rises on the 9th rising edge after the edge that captured the samples, and `u_out` changes on that same edge.
- R3: `u_out` is computed from acc = t0·uc(k) + t1·uc(k−1) + t2·uc(k−2) − s0·y(k) − s1·y(k−1) − s2·y(k−2) − r1·u(k−1) − r2·u(k−2). The coefficients are signed CW-bit values with FRAC fraction bits. The samples are signed DW-bit integers.
- R4: The accumulator is rounded by adding 2^(FRAC−1) and then shifting right arithmetically by FRAC bits, so ties round toward plus infinity.
- R5: A rounded result above 2^(DW−1)−1 gives 2^(DW−1)−1. A result below −2^(DW−1) gives −2^(DW−1). There is no wrap.
- R6: After each output, the delayed samples of `uc`, `y` and `u` move one place. The next computation uses the previous two samples of each.
- R7: `cf_we` writes `cf_data` into the shadow entry selected by `cf_addr`, using the order 0=t0, 1=t1, 2=t2, 3=s0, 4=s1, 5=s2, 6=r1, 7=r2. A write has no effect on an update already running or on `u_out` before the next sample strobe.
- R8: On the strobe edge, all eight shadow entries are copied to the active set together. A write in the strobe cycle itself lands only in the shadow and takes effect one strobe later.
- R9: A synchronous reset clears the divider, every delayed sample, `u_out`, `u_valid` and both coefficient banks to zero.
- R10: `u_out` holds its value in every cycle without a valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| uc_in | input | DW | Commanded trajectory sample, signed |
| y_in | input | DW | Measured plant output sample, signed |
| cf_we | input | 1 | Shadow coefficient write enable |
| cf_addr | input | 3 | Shadow coefficient index |
| cf_data | input | CW | Coefficient value, signed, FRAC fraction bits |
| u_out | output | DW | Registered control value, signed |
| u_valid | output | 1 | One-cycle pulse marking a new `u_out` |
| sample_tick | output | 1 | Sample strobe, high one cycle per period |

## Verification
A strobe is visible in the cycle it is high. The capture and the coefficient commit happen on the edge that ends that cycle. The eight products accumulate over the next eight edges, and the result and valid pulse appear after the ninth edge. The bench model advances on every rising edge and follows the same counts: a pending counter is set to 9 at the strobe edge and produces the expected value when it reaches zero. Divider position, valid and output are all compared at the falling edge, half a cycle after each update. Coefficient writes are placed in the strobe cycle and in the middle of an accumulation, so that the commit edge is tested at both places.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;

  localparam int NCOEF = 8;

  typedef enum logic [2:0] {
    K_T0 = 3'd0, K_T1 = 3'd1, K_T2 = 3'd2,
    K_S0 = 3'd3, K_S1 = 3'd4, K_S2 = 3'd5,
    K_R1 = 3'd6, K_R2 = 3'd7
  } coef_idx_e;

  // Terms from index K_S0 upward enter with a minus sign.
  localparam logic [NCOEF-1:0] NEG_MASK = 8'b1111_1000;

  // Round half toward plus infinity, then drop frac bits.
  function automatic logic signed [63:0] round_q(input logic signed [63:0] a,
                                                  input int frac);
    logic signed [63:0] half;
    half = 64'sd1 <<< (frac - 1);
    return (a + half) >>> frac;
  endfunction

  // Clamp to the signed range of a dw-bit word.
  function automatic logic signed [63:0] clamp_w(input logic signed [63:0] v,
                                                  input int dw);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (dw - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/rst_tick_gen.sv
module rst_tick_gen #(
  parameter int DIV = 250000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNTW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNTW-1:0] cnt;

  assign tick = (cnt == CNTW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/rst_coef_bank.sv
module rst_coef_bank #(
  parameter int CW  = 18,
  parameter int N   = 8,
  parameter int CAW = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [CAW-1:0]         addr,
  input  logic [CW-1:0]          wdata,
  input  logic                   commit,
  output logic [N-1:0][CW-1:0]   active
);
  logic [N-1:0][CW-1:0] shadow;

  for (genvar i = 0; i < N; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)                            shadow[i] <= '0;
      else if (we && addr == CAW'(i))     shadow[i] <= wdata;
    end
    always_ff @(posedge clk) begin
      if (rst)         active[i] <= '0;
      else if (commit) active[i] <= shadow[i];
    end
  end

  assert_active_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(active));

endmodule

// File: rtl/rst_hist.sv
module rst_hist #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cap,
  input  logic                  adv,
  input  logic [W-1:0]          din,
  output logic [DEPTH:0][W-1:0] taps
);
  always_ff @(posedge clk) begin
    if (rst)      taps[0] <= '0;
    else if (cap) taps[0] <= din;
  end

  for (genvar i = 1; i <= DEPTH; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst)      taps[i] <= '0;
      else if (adv) taps[i] <= taps[i-1];
    end
  end

  assert_taps_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!cap && !adv) |=> $stable(taps));

endmodule

// File: rtl/rst_mac_seq.sv
module rst_mac_seq #(
  parameter int DW = 16,
  parameter int CW = 18,
  parameter int AW = 40,
  parameter int N  = 8,
  parameter logic [N-1:0] NEG = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [N-1:0][CW-1:0]  coefs,
  input  logic [N-1:0][DW-1:0]  ops,
  output logic [AW-1:0]         acc,
  output logic                  busy,
  output logic                  fin
);
  localparam int SW = (N > 1) ? $clog2(N) : 1;
  localparam int PW = CW + DW;

  logic [SW-1:0]         step;
  logic signed [PW-1:0]  prod;
  logic signed [AW-1:0]  prod_x;
  logic signed [AW-1:0]  term;
  logic                  last_step;

  assign prod      = $signed(coefs[step]) * $signed(ops[step]);
  assign prod_x    = {{(AW-PW){prod[PW-1]}}, prod};
  assign term      = NEG[step] ? -prod_x : prod_x;
  assign last_step = (step == SW'(N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      busy <= 1'b0;
      step <= '0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        acc  <= '0;
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        acc <= acc + term;
        if (last_step) begin
          busy <= 1'b0;
          fin  <= 1'b1;
          step <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  assert_mac_end_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && last_step && !start) |=> (fin && !busy));

  assert_fin_single_R2: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);

endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl #(
  parameter int DW   = 16,
  parameter int CW   = 18,
  parameter int FRAC = 14,
  parameter int AW   = 40,
  parameter int DIV  = 250000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] uc_in,
  input  logic [DW-1:0] y_in,
  input  logic          cf_we,
  input  logic [2:0]    cf_addr,
  input  logic [CW-1:0] cf_data,
  output logic [DW-1:0] u_out,
  output logic          u_valid,
  output logic          sample_tick
);
  import rst_ctrl_pkg::*;

  localparam int NC = NCOEF;
  localparam logic signed [63:0] UMAX = (64'sd1 <<< (DW - 1)) - 64'sd1;
  localparam logic signed [63:0] UMIN = -UMAX - 64'sd1;

  logic                   tick;
  logic [NC-1:0][CW-1:0]  coef_act;
  logic [2:0][DW-1:0]     uc_t;
  logic [2:0][DW-1:0]     y_t;
  logic [1:0][DW-1:0]     u_t;
  logic [NC-1:0][DW-1:0]  ops;
  logic [AW-1:0]          acc;
  logic                   mac_busy;
  logic                   mac_fin;
  logic signed [63:0]     acc_x;
  logic signed [63:0]     rnd_v;
  logic signed [63:0]     sat_v;
  logic [DW-1:0]          u_next;
  logic                   rnd_over_hi;
  logic                   rnd_under_lo;
  logic                   valid_q;

  rst_tick_gen #(.DIV(DIV)) tick_i (
    .clk(clk), .rst(rst), .tick(tick)
  );

  rst_coef_bank #(.CW(CW), .N(NC), .CAW(3)) bank_i (
    .clk(clk), .rst(rst), .we(cf_we), .addr(cf_addr), .wdata(cf_data),
    .commit(tick), .active(coef_act)
  );

  rst_hist #(.W(DW), .DEPTH(2)) uc_hist_i (
    .clk(clk), .rst(rst), .cap(tick), .adv(mac_fin), .din(uc_in), .taps(uc_t)
  );

  rst_hist #(.W(DW), .DEPTH(2)) y_hist_i (
    .clk(clk), .rst(rst), .cap(tick), .adv(mac_fin), .din(y_in), .taps(y_t)
  );

  // u history: tap 0 is the current output, tap 1 the one before it.
  rst_hist #(.W(DW), .DEPTH(1)) u_hist_i (
    .clk(clk), .rst(rst), .cap(mac_fin), .adv(mac_fin), .din(u_next), .taps(u_t)
  );

  always_comb begin
    ops[K_T0] = uc_t[0];
    ops[K_T1] = uc_t[1];
    ops[K_T2] = uc_t[2];
    ops[K_S0] = y_t[0];
    ops[K_S1] = y_t[1];
    ops[K_S2] = y_t[2];
    ops[K_R1] = u_t[0];
    ops[K_R2] = u_t[1];
  end

  rst_mac_seq #(.DW(DW), .CW(CW), .AW(AW), .N(NC), .NEG(NEG_MASK)) mac_i (
    .clk(clk), .rst(rst), .start(tick), .coefs(coef_act), .ops(ops),
    .acc(acc), .busy(mac_busy), .fin(mac_fin)
  );

  assign acc_x        = {{(64-AW){acc[AW-1]}}, acc};
  assign rnd_v        = round_q(acc_x, FRAC);
  assign sat_v        = clamp_w(rnd_v, DW);
  assign u_next       = sat_v[DW-1:0];
  assign rnd_over_hi  = (rnd_v > UMAX);
  assign rnd_under_lo = (rnd_v < UMIN);

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= mac_fin;
  end

  assign u_out       = u_t[0];
  assign u_valid     = valid_q;
  assign sample_tick = tick;

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    u_valid |=> !u_valid);

  assert_valid_after_mac_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(u_valid) |-> $past(mac_fin));

  assert_u_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !mac_fin |=> $stable(u_out));

  assert_sat_hi_R5: assert property (@(posedge clk) disable iff (rst)
    (mac_fin && rnd_over_hi) |=> (u_out == UMAX[DW-1:0]));

  assert_sat_lo_R5: assert property (@(posedge clk) disable iff (rst)
    (mac_fin && rnd_under_lo) |=> (u_out == UMIN[DW-1:0]));

  assert_no_tick_in_mac_R1: assert property (@(posedge clk) disable iff (rst)
    mac_busy |-> !tick);

endmodule

// File: tb/rst_ctrl_tb_top.sv
module rst_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int CW   = 18;
  localparam int FRAC = 14;
  localparam int DIV  = 16;
  localparam int WD_CYCLES = 100000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] uc_in = '0;
  logic [DW-1:0] y_in  = '0;
  logic          cf_we = 1'b0;
  logic [2:0]    cf_addr = '0;
  logic [CW-1:0] cf_data = '0;
  logic [DW-1:0] u_out;
  logic          u_valid;
  logic          sample_tick;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_ctrl #(.DW(DW), .CW(CW), .FRAC(FRAC), .AW(40), .DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .uc_in(uc_in), .y_in(y_in), .cf_we(cf_we),
    .cf_addr(cf_addr), .cf_data(cf_data), .u_out(u_out), .u_valid(u_valid),
    .sample_tick(sample_tick)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  string cur_req = "R3";

  // ---------------- behavioural reference model ----------------
  longint shd[8];
  longint act[8];
  longint uc_h[$];   // front = newest (k), then k-1, k-2
  longint y_h[$];
  longint u_h[$];    // front = newest output
  int     mcnt;
  int     pend;
  bit     exp_valid;
  longint exp_u;

  function automatic longint sx(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint produce();
    longint a, r;
    a = act[0]*uc_h[0] + act[1]*uc_h[1] + act[2]*uc_h[2]
      - act[3]*y_h[0]  - act[4]*y_h[1]  - act[5]*y_h[2]
      - act[6]*u_h[0]  - act[7]*u_h[1];
    r = (a + 8192) >>> FRAC;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 8; i++) begin shd[i] = 0; act[i] = 0; end
    uc_h = '{0, 0, 0};
    y_h  = '{0, 0, 0};
    u_h  = '{0, 0};
    mcnt = 0; pend = 0; exp_valid = 0; exp_u = 0;
  endtask

  initial model_clear();

  always @(posedge clk) begin
    if (rst) begin
      model_clear();
    end else begin
      bit t;
      t = (mcnt == DIV - 1);
      mcnt = t ? 0 : mcnt + 1;
      exp_valid = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          longint nu;
          nu = produce();
          void'(uc_h.pop_back()); uc_h.insert(1, uc_h[0]);
          void'(y_h.pop_back());  y_h.insert(1, y_h[0]);
          void'(u_h.pop_back());  u_h.push_front(nu);
          exp_u = nu;
          exp_valid = 1;
        end
      end
      if (t) begin
        uc_h[0] = sx(uc_in);
        y_h[0]  = sx(y_in);
        for (int i = 0; i < 8; i++) act[i] = shd[i];
        pend = 9;
      end
      if (cf_we) shd[cf_addr] = longint'($signed(cf_data));
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic chk(input string req, input longint act_v, input longint exp_v,
                     input string what);
    total++;
    if (act_v != exp_v) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what,
               act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1", longint'(sample_tick), longint'(mcnt == DIV - 1), "sample_tick");
      chk("R2", longint'(u_valid), longint'(exp_valid), "u_valid");
      chk(exp_valid ? cur_req : "R10", sx(u_out), exp_u, "u_out");
    end
  end

  // ---------------- stimulus helpers ----------------
  int unsigned lcg = 32'h1234_5678;
  function automatic int pseudo(input int span);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 8) % (2 * span + 1)) - span;
  endfunction

  task automatic wcoef(input int idx, input int val);
    @(negedge clk);
    cf_we = 1'b1; cf_addr = 3'(idx); cf_data = CW'(val);
    @(negedge clk);
    cf_we = 1'b0;
  endtask

  task automatic set_all(input int v0, v1, v2, v3, v4, v5, v6, v7);
    wcoef(0, v0); wcoef(1, v1); wcoef(2, v2); wcoef(3, v3);
    wcoef(4, v4); wcoef(5, v5); wcoef(6, v6); wcoef(7, v7);
  endtask

  task automatic wait_out();
    @(negedge clk);
    while (!exp_valid) @(negedge clk);
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (mcnt != DIV - 1) @(negedge clk);
  endtask

  task automatic run(input int n, input int span, input bit drive_y);
    for (int i = 0; i < n; i++) begin
      uc_in = DW'(pseudo(span));
      if (drive_y) y_in = DW'(pseudo(span));
      wait_out();
    end
  endtask

  task automatic run_fixed(input int uc_v);
    uc_in = DW'(uc_v);
    wait_out();
  endtask

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", sx(u_out), 0, "u_out after reset");
    chk("R9", longint'(u_valid), 0, "u_valid after reset");

    // Identity: t0 = 1.0, u follows uc (R3)
    cur_req = "R3";
    set_all(16384, 0, 0, 0, 0, 0, 0, 0);
    wait_out();
    run(6, 3000, 1'b0);

    // Full coefficient set, both inputs varying (R3, R6)
    cur_req = "R6";
    set_all(8192, 4096, -2048, 6000, -3000, 1000, -8000, 2000);
    wait_out();
    run(12, 3000, 1'b1);

    // Rounding ties and negative values (R4)
    cur_req = "R4";
    y_in = '0;
    set_all(8192, 0, 0, 0, 0, 0, 0, 0);
    wait_out();
    run_fixed(1); run_fixed(-1); run_fixed(3); run_fixed(-3); run_fixed(0);
    wait_out();

    // Saturation both ways (R5)
    cur_req = "R5";
    set_all(131071, 0, 0, 0, 0, 0, 0, 0);
    wait_out();
    run_fixed(20000); run_fixed(-20000); run_fixed(32767); run_fixed(-32768);
    wait_out();

    // Write in the strobe cycle lands one period late (R8)
    cur_req = "R8";
    uc_in = DW'(1000);
    wait_tick();
    cf_we = 1'b1; cf_addr = 3'd0; cf_data = CW'(4096);
    @(negedge clk);
    cf_we = 1'b0;
    wait_out();
    wait_out();
    wait_out();

    // Write during accumulation does not disturb it (R7)
    cur_req = "R7";
    wait_tick();
    repeat (3) @(negedge clk);
    cf_we = 1'b1; cf_addr = 3'd0; cf_data = CW'(-16384);
    @(negedge clk);
    cf_we = 1'b0;
    wait_out();
    wait_out();
    wait_out();

    // Mid-run reset clears histories and banks (R9)
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", sx(u_out), 0, "u_out after mid reset");
    cur_req = "R9";
    set_all(0, 0, 0, 0, 0, 0, -16384, 0);
    wait_out();
    wait_out();
    run(3, 2000, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule